// File: doc/BRIEF.md
# Load Data Aligner and Base Writeback Stage

This block sits directly after the data memory read in a 32-bit load/store pipeline. It takes the naturally aligned 32-bit word returned by memory, together with the byte address of the access, and produces the value to be written to the destination register. Byte, halfword and word loads are supported. The low address bits pick the byte or halfword lane, or set the rotation applied to a word. Sign or zero extension follows the signedness of the access. A variant select chooses between two core generations. The older generation rotates halfwords fetched from odd addresses. The newer one never rotates halfwords.

The same stage finishes base-register update for indexed addressing. For pre-indexed accesses the incoming address is already the final address, and that address is written back. For post-indexed accesses the signed offset is added to it. The program counter is never written through this path. When the base is the program counter, the newer variant drops the update. The older variant turns it into a fetch redirect. A load that redirects discards its loaded data.

All results are registered once, and the output valid trails the input valid by exactly one clock.

Top module: `ldst_align_wb`

## Requirements
- R1: Every output is registered. `outValid` equals `inValid` of the previous cycle. A cycle without `inValid` gives low `destWe`, `baseWe` and `jumpValid` one cycle later. Synchronous active-high `rst` clears `outValid`, `destWe`, `baseWe` and `jumpValid`.
- R2: A word load (`accSize` = 2, and 3 is also treated as word) returns the memory word rotated right by 8 x `addr[1:0]` bits.
- R3: A byte load (`accSize` = 0) takes byte lane `addr[1:0]` of the memory word (lane 0 = bits 7:0). With `isSigned` = 0 it is zero-extended. With `isSigned` = 1 its bit 7 is copied into bits 31:8.
- R4: On the newer variant (`legacyCore` = 0), a halfword load (`accSize` = 1) takes halfword lane `addr[1]` (lane 0 = bits 15:0) and never rotates it. It is zero-extended, or sign-extended from bit 15 when `isSigned` = 1.
- R5: On the older variant (`legacyCore` = 1), a halfword load zero-extends halfword lane `addr[1]` to 32 bits and then rotates it right by 8 x `addr[0]`. When signed, an even address sign-extends from bit 15 and an odd address sign-extends from bit 7 of the rotated value.
- R6: The writeback address is `addr` for pre-indexed mode (`wbMode` = 1). For post-indexed mode (`wbMode` = 2) it is `addr + offset`, with `offset` read as two's complement. Modes 0 and 3 mean no writeback.
- R7: `baseWe` is raised exactly when the access was valid, the writeback mode is pre- or post-indexed, and `baseIdx` is not 15. In that case `baseData` carries the writeback address and `baseIdxOut` carries `baseIdx`.
- R8: On the newer variant a base of 15 causes neither a base write nor a redirect. A load still writes its destination.
- R9: On the older variant, a load with writeback and base 15 raises `jumpValid` with target (writeback address + 4) and bit 0 cleared. It leaves `destWe` and `baseWe` low.
- R10: On the older variant, a store with writeback and base 15 raises `jumpValid` with target equal to the writeback address with bit 0 cleared.
- R11: A store (`isLoad` = 0) never raises `destWe`. A load that does not redirect raises `destWe` with `destIdxOut` equal to `destIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Access presented this cycle |
| isLoad | input | 1 | 1 = load, 0 = store |
| rawWord | input | 32 | Aligned word read from memory |
| addr | input | 32 | Byte address of the access |
| offset | input | 32 | Signed index offset used by post-indexing |
| accSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| isSigned | input | 1 | Sign-extend byte/halfword loads |
| wbMode | input | 2 | 0 none, 1 pre-indexed, 2 post-indexed, 3 none |
| baseIdx | input | 4 | Base register index |
| destIdx | input | 4 | Destination register index |
| legacyCore | input | 1 | 1 = older variant, 0 = newer variant |
| outValid | output | 1 | Result valid, one cycle after inValid |
| destWe | output | 1 | Destination register write enable |
| destIdxOut | output | 4 | Destination register index |
| destData | output | 32 | Aligned, extended load data |
| baseWe | output | 1 | Base register write enable |
| baseIdxOut | output | 4 | Base register index |
| baseData | output | 32 | Base writeback value |
| jumpValid | output | 1 | Fetch redirect request |
| jumpTarget | output | 32 | Redirect address, bit 0 clear |

## Verification
The bench aims at the odd-address halfword on the older variant, where sign extension must come from the byte rotated into the low lane. A design that extends from bit 15 there, or skips the rotation, returns the wrong upper bits. It also drives base index 15 in both variants and with both directions. A wrong design here writes the program counter as a register, misses the +4 on load redirects, leaves bit 0 set, or keeps the destination write of a redirecting load. Negative post-index offsets and every word rotation amount are covered, so a zero-extended offset or a reversed rotation direction shows up as a wrong `baseData` or `destData`.

// File: rtl/ldwb_pkg.sv
package ldwb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    WB_NONE = 2'd0,
    WB_PRE  = 2'd1,
    WB_POST = 2'd2,
    WB_OFF  = 2'd3
  } wbMode_e;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;    // access present, load the result registers
    logic destWe;     // destination write will be issued
    logic baseWe;     // base register write will be issued
    logic jumpValid;  // base is PC on the older variant: redirect
    logic jumpPlus4;  // redirect came from a load: add 4
    logic usePost;    // add offset to form writeback address
  } ldwbStrobe_t;

endpackage

// File: rtl/ldwb_aligner.sv
module ldwb_aligner
  import ldwb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]               rawWord,
  input  logic [$clog2(DATA_W/8)-1:0]     laneSel,
  input  logic [1:0]                      accSize,
  input  logic                            isSigned,
  input  logic                            legacyCore,
  output logic [DATA_W-1:0]               alignedData
);

  localparam int NUM_BYTES  = DATA_W / 8;
  localparam int NUM_HALVES = DATA_W / 16;
  localparam int LANE_W     = $clog2(NUM_BYTES);
  localparam int ROT_W      = LANE_W + 3;

  logic [7:0]  byteLane [NUM_BYTES];
  logic [15:0] halfLane [NUM_HALVES];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
      assign byteLane[gi] = rawWord[8*gi +: 8];
    end
    for (gi = 0; gi < NUM_HALVES; gi++) begin : g_half
      assign halfLane[gi] = rawWord[16*gi +: 16];
    end
  endgenerate

  logic [ROT_W-1:0]      rotAmt;
  logic [2*DATA_W-1:0]   wordDouble;
  logic [2*DATA_W-1:0]   wordShift;
  logic [DATA_W-1:0]     wordRot;
  logic [7:0]            byteSel;
  logic [15:0]           halfSel;
  logic [DATA_W-1:0]     halfZext;
  logic [2*DATA_W-1:0]   halfDouble;
  logic [2*DATA_W-1:0]   halfShift;
  logic [DATA_W-1:0]     halfRotOdd;
  logic [DATA_W-1:0]     byteResult;
  logic [DATA_W-1:0]     halfNewer;
  logic [DATA_W-1:0]     halfOlder;

  // word: rotate right by eight times the lane number
  assign rotAmt     = {laneSel, 3'b000};
  assign wordDouble = {rawWord, rawWord};
  assign wordShift  = wordDouble >> rotAmt;
  assign wordRot    = wordShift[DATA_W-1:0];

  assign byteSel = byteLane[laneSel];
  generate
    if (LANE_W > 1) begin : g_half_sel_multi
      assign halfSel = halfLane[laneSel[LANE_W-1:1]];
    end else begin : g_half_sel_single
      assign halfSel = halfLane[0];
    end
  endgenerate

  // older variant: halfword is zero-extended, then rotated by one byte if odd
  assign halfZext   = {{(DATA_W-16){1'b0}}, halfSel};
  assign halfDouble = {halfZext, halfZext};
  assign halfShift  = halfDouble >> 8;
  assign halfRotOdd = halfShift[DATA_W-1:0];

  always_comb begin
    if (isSigned) byteResult = {{(DATA_W-8){byteSel[7]}}, byteSel};
    else          byteResult = {{(DATA_W-8){1'b0}}, byteSel};
  end

  always_comb begin
    if (isSigned) halfNewer = {{(DATA_W-16){halfSel[15]}}, halfSel};
    else          halfNewer = halfZext;
  end

  always_comb begin
    if (laneSel[0]) begin
      // the rotated value has the upper byte of the halfword in bits 7:0
      if (isSigned) halfOlder = {{(DATA_W-8){halfRotOdd[7]}}, halfRotOdd[7:0]};
      else          halfOlder = halfRotOdd;
    end else begin
      halfOlder = halfNewer;
    end
  end

  always_comb begin
    unique case (accSize)
      SZ_BYTE: alignedData = byteResult;
      SZ_HALF: alignedData = legacyCore ? halfOlder : halfNewer;
      default: alignedData = wordRot;
    endcase
  end

endmodule

// File: rtl/ldwb_ctrl.sv
module ldwb_ctrl
  import ldwb_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 isLoad,
  input  logic [1:0]           wbMode,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic                 legacyCore,
  output ldwbStrobe_t          strb,
  output logic                 outValid,
  output logic                 destWe,
  output logic                 baseWe,
  output logic                 jumpValid
);

  localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

  logic wbActive;
  logic baseIsPc;

  assign wbActive = inValid && ((wbMode == WB_PRE) || (wbMode == WB_POST));
  assign baseIsPc = (baseIdx == PC_CODE);

  always_comb begin
    strb           = '0;
    strb.capture   = inValid;
    strb.usePost   = (wbMode == WB_POST);
    strb.jumpPlus4 = isLoad;
    strb.baseWe    = wbActive && !baseIsPc;
    strb.jumpValid = wbActive && baseIsPc && legacyCore;
    strb.destWe    = inValid && isLoad && !strb.jumpValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      destWe    <= 1'b0;
      baseWe    <= 1'b0;
      jumpValid <= 1'b0;
    end else begin
      outValid  <= strb.capture;
      destWe    <= strb.destWe;
      baseWe    <= strb.baseWe;
      jumpValid <= strb.jumpValid;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !destWe && !baseWe && !jumpValid));  // R1
  AST_PC_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (inValid && baseIdx == PC_CODE) |=> !baseWe);  // R7
  AST_NEWER_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (inValid && !legacyCore) |=> !jumpValid);  // R8
  AST_JUMP_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
    jumpValid |-> (!destWe && !baseWe));  // R9
  AST_STORE_NO_DEST: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isLoad) |=> !destWe);  // R11

endmodule

// File: rtl/ldwb_datapath.sv
module ldwb_datapath
  import ldwb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ldwbStrobe_t          strb,
  input  logic [DATA_W-1:0]    rawWord,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    offset,
  input  logic [1:0]           accSize,
  input  logic                 isSigned,
  input  logic                 legacyCore,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [REG_IDX_W-1:0] destIdx,
  output logic [REG_IDX_W-1:0] destIdxOut,
  output logic [DATA_W-1:0]    destData,
  output logic [REG_IDX_W-1:0] baseIdxOut,
  output logic [ADDR_W-1:0]    baseData,
  output logic [ADDR_W-1:0]    jumpTarget
);

  localparam int LANE_W = $clog2(DATA_W/8);
  localparam logic [ADDR_W-1:0] PC_AHEAD = ADDR_W'(4);

  logic [DATA_W-1:0] alignedData;
  logic [ADDR_W-1:0] wbAddr;
  logic [ADDR_W-1:0] jumpSum;
  logic [ADDR_W-1:0] jumpAddr;

  ldwb_aligner #(.DATA_W(DATA_W)) u_aligner (
    .rawWord    (rawWord),
    .laneSel    (addr[LANE_W-1:0]),
    .accSize    (accSize),
    .isSigned   (isSigned),
    .legacyCore (legacyCore),
    .alignedData(alignedData)
  );

  // pre-indexed: address is already final; post-indexed: add the offset
  assign wbAddr   = strb.usePost ? (addr + offset) : addr;
  assign jumpSum  = strb.jumpPlus4 ? (wbAddr + PC_AHEAD) : wbAddr;
  assign jumpAddr = {jumpSum[ADDR_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      destIdxOut <= '0;
      destData   <= '0;
      baseIdxOut <= '0;
      baseData   <= '0;
      jumpTarget <= '0;
    end else if (strb.capture) begin
      destIdxOut <= destIdx;
      destData   <= alignedData;
      baseIdxOut <= baseIdx;
      baseData   <= wbAddr;
      jumpTarget <= jumpAddr;
    end
  end

  AST_PRE_WB_ADDR: assert property (@(posedge clk) disable iff (rst)
    (strb.baseWe && !strb.usePost) |=> (baseData == $past(addr)));  // R6
  AST_JUMP_EVEN: assert property (@(posedge clk) disable iff (rst)
    strb.jumpValid |=> !jumpTarget[0]);  // R9
  AST_UBYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (strb.destWe && accSize == SZ_BYTE && !isSigned) |=> (destData[DATA_W-1:8] == '0));  // R3
  AST_NEWER_HALF_UPPER: assert property (@(posedge clk) disable iff (rst)
    (strb.destWe && accSize == SZ_HALF && !legacyCore && !isSigned)
      |=> (destData[DATA_W-1:16] == '0));  // R4
  AST_DEST_IDX_KEPT: assert property (@(posedge clk) disable iff (rst)
    strb.destWe |=> (destIdxOut == $past(destIdx)));  // R11

endmodule

// File: rtl/ldst_align_wb.sv
module ldst_align_wb
  import ldwb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int REG_IDX_W = 4,
  parameter int PC_IDX    = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 isLoad,
  input  logic [DATA_W-1:0]    rawWord,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    offset,
  input  logic [1:0]           accSize,
  input  logic                 isSigned,
  input  logic [1:0]           wbMode,
  input  logic [REG_IDX_W-1:0] baseIdx,
  input  logic [REG_IDX_W-1:0] destIdx,
  input  logic                 legacyCore,
  output logic                 outValid,
  output logic                 destWe,
  output logic [REG_IDX_W-1:0] destIdxOut,
  output logic [DATA_W-1:0]    destData,
  output logic                 baseWe,
  output logic [REG_IDX_W-1:0] baseIdxOut,
  output logic [ADDR_W-1:0]    baseData,
  output logic                 jumpValid,
  output logic [ADDR_W-1:0]    jumpTarget
);

  ldwbStrobe_t strb;

  ldwb_ctrl #(
    .REG_IDX_W(REG_IDX_W),
    .PC_IDX   (PC_IDX)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .isLoad    (isLoad),
    .wbMode    (wbMode),
    .baseIdx   (baseIdx),
    .legacyCore(legacyCore),
    .strb      (strb),
    .outValid  (outValid),
    .destWe    (destWe),
    .baseWe    (baseWe),
    .jumpValid (jumpValid)
  );

  ldwb_datapath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .REG_IDX_W(REG_IDX_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .rawWord   (rawWord),
    .addr      (addr),
    .offset    (offset),
    .accSize   (accSize),
    .isSigned  (isSigned),
    .legacyCore(legacyCore),
    .baseIdx   (baseIdx),
    .destIdx   (destIdx),
    .destIdxOut(destIdxOut),
    .destData  (destData),
    .baseIdxOut(baseIdxOut),
    .baseData  (baseData),
    .jumpTarget(jumpTarget)
  );

endmodule

// File: tb/ldst_align_wb_tb.sv
`timescale 1ns/1ps
module ldst_align_wb_tb;

  localparam real CLK_HALF = 2.0;  // 250 MHz
  localparam int  WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, isLoad, isSigned, legacyCore;
  logic [31:0] rawWord, addr, offset;
  logic [1:0]  accSize, wbMode;
  logic [3:0]  baseIdx, destIdx;
  logic        outValid, destWe, baseWe, jumpValid;
  logic [3:0]  destIdxOut, baseIdxOut;
  logic [31:0] destData, baseData, jumpTarget;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_HALF) clk = ~clk;

  ldst_align_wb u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .isLoad(isLoad), .rawWord(rawWord),
    .addr(addr), .offset(offset), .accSize(accSize), .isSigned(isSigned),
    .wbMode(wbMode), .baseIdx(baseIdx), .destIdx(destIdx), .legacyCore(legacyCore),
    .outValid(outValid), .destWe(destWe), .destIdxOut(destIdxOut), .destData(destData),
    .baseWe(baseWe), .baseIdxOut(baseIdxOut), .baseData(baseData),
    .jumpValid(jumpValid), .jumpTarget(jumpTarget)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelData(input logic [31:0] w, input logic [31:0] a,
                                             input logic [1:0] sz, input logic sg, input logic old);
    logic [63:0] dbl;
    logic [31:0] rot;
    logic [7:0]  b;
    logic [15:0] h;
    dbl = {w, w} >> (a[1:0] * 8);
    rot = dbl[31:0];
    case (a[1:0])
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 2'd0) return sg ? {{24{b[7]}}, b} : {24'h0, b};
    if (sz == 2'd1) begin
      if (old && a[0]) return sg ? {{24{h[15]}}, h[15:8]} : {h[7:0], 16'h0, h[15:8]};
      return sg ? {{16{h[15]}}, h} : {16'h0, h};
    end
    return rot;
  endfunction

  function automatic string dataReq(input logic [1:0] sz, input logic old);
    if (sz == 2'd0) return "R3";
    if (sz == 2'd1) return old ? "R5" : "R4";
    return "R2";
  endfunction

  // drive one access at a falling edge, check the registered result at the next one
  task automatic access(input logic ld, input logic [31:0] w, input logic [31:0] a,
                        input logic [31:0] off, input logic [1:0] sz, input logic sg,
                        input logic [1:0] wm, input logic [3:0] bi, input logic [3:0] di,
                        input logic old);
    logic wbOn, pcBase, expJump, expDest, expBase;
    logic [31:0] wbA, tgt;
    inValid = 1'b1; isLoad = ld; rawWord = w; addr = a; offset = off; accSize = sz;
    isSigned = sg; wbMode = wm; baseIdx = bi; destIdx = di; legacyCore = old;
    wbOn    = (wm == 2'd1) || (wm == 2'd2);
    pcBase  = (bi == 4'd15);
    wbA     = (wm == 2'd2) ? a + off : a;
    expJump = wbOn && pcBase && old;
    expBase = wbOn && !pcBase;
    expDest = ld && !expJump;
    tgt     = (ld ? wbA + 32'd4 : wbA) & 32'hFFFF_FFFE;
    @(negedge clk);
    inValid = 1'b0;
    check("R1", "outValid", {31'h0, outValid}, 32'h1);
    check(!ld ? "R11" : (expJump ? "R9" : "R8"), "destWe", {31'h0, destWe}, {31'h0, expDest});
    if (expDest) begin
      check(dataReq(sz, old), "destData", destData, modelData(w, a, sz, sg, old));
      check("R11", "destIdxOut", {28'h0, destIdxOut}, {28'h0, di});
    end
    check("R7", "baseWe", {31'h0, baseWe}, {31'h0, expBase});
    if (expBase) begin
      check("R6", "baseData", baseData, wbA);
      check("R7", "baseIdxOut", {28'h0, baseIdxOut}, {28'h0, bi});
    end
    check(expJump ? (ld ? "R9" : "R10") : "R8", "jumpValid", {31'h0, jumpValid}, {31'h0, expJump});
    if (expJump) check(ld ? "R9" : "R10", "jumpTarget", jumpTarget, tgt);
  endtask

  task automatic idleCheck();
    inValid = 1'b0;
    @(negedge clk);
    check("R1", "idle outValid", {31'h0, outValid}, 32'h0);
    check("R1", "idle enables", {29'h0, destWe, baseWe, jumpValid}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    rst = 1'b1; inValid = 1'b0; isLoad = 1'b0; rawWord = '0; addr = '0; offset = '0;
    accSize = '0; isSigned = 1'b0; wbMode = '0; baseIdx = '0; destIdx = '0; legacyCore = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset outValid", {31'h0, outValid}, 32'h0);
    check("R1", "reset enables", {29'h0, destWe, baseWe, jumpValid}, 32'h0);
    rst = 1'b0;

    // R2 every rotation amount
    for (int l = 0; l < 4; l++)
      access(1, 32'h1122_3344, 32'h100 + l, 0, 2'd2, 0, 2'd0, 4'd1, 4'd2, l[0]);
    // R3 signed and unsigned bytes in upper lane
    access(1, 32'hFF00_7F00, 32'h203, 0, 2'd0, 1, 2'd0, 4'd1, 4'd3, 0);
    access(1, 32'hFF00_7F00, 32'h203, 0, 2'd0, 0, 2'd0, 4'd1, 4'd3, 0);
    // R4 newer signed halfword, odd address: no rotation
    access(1, 32'h8001_1234, 32'h303, 0, 2'd1, 1, 2'd0, 4'd1, 4'd4, 0);
    // R5 older odd address, signed and unsigned
    access(1, 32'h0000_80F0, 32'h301, 0, 2'd1, 1, 2'd0, 4'd1, 4'd4, 1);
    access(1, 32'h0000_7FF0, 32'h301, 0, 2'd1, 1, 2'd0, 4'd1, 4'd4, 1);
    access(1, 32'h0000_80F0, 32'h301, 0, 2'd1, 0, 2'd0, 4'd1, 4'd4, 1);
    access(1, 32'h8001_0000, 32'h302, 0, 2'd1, 1, 2'd0, 4'd1, 4'd4, 1);
    // R6 post-index with negative offset, pre-index
    access(1, 32'h0, 32'h1000, 32'hFFFF_FFF0, 2'd2, 0, 2'd2, 4'd5, 4'd6, 0);
    access(0, 32'h0, 32'h2004, 32'h0000_0040, 2'd2, 0, 2'd1, 4'd5, 4'd6, 0);
    // R8 newer, base PC
    access(1, 32'hCAFE_F00D, 32'h400, 32'h8, 2'd2, 0, 2'd2, 4'd15, 4'd7, 0);
    // R9 older load, base PC, odd post result
    access(1, 32'hCAFE_F00D, 32'h401, 32'h2, 2'd0, 0, 2'd2, 4'd15, 4'd7, 1);
    // R10 older store, base PC, pre-index odd
    access(0, 32'h0, 32'h503, 32'h0, 2'd2, 0, 2'd1, 4'd15, 4'd0, 1);
    idleCheck();

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] bi;
      bi = ($urandom % 4 == 0) ? 4'd15 : 4'($urandom);
      access(1'($urandom), $urandom, $urandom, $urandom, 2'($urandom), 1'($urandom),
             2'($urandom), bi, 4'($urandom), 1'($urandom));
      if ($urandom % 16 == 0) idleCheck();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule